// File: doc/BRIEF.md
# Bus Drop Frame Handler

This block sits on a drop of a shared head-to-drops serial bus, behind the reassembler that rebuilds one frame from its four line bytes. Each decoded frame carries a token count (how many of its two payload bytes carry packet data), a channel select, a 5-bit tap address and the two payload bytes. The block turns these frames into a common time base, a transmit-slot grant and per-channel packet streams.

Every frame produces a one-cycle tick and advances a wrapping tick counter. A frame tapping address 0 resynchronises all drops by clearing the counter. A frame tapping this drop's own address grants it the uplink slot for that frame cycle. Payload is split by channel. The realtime channel (A) is passed through unfiltered. On the info channel (B), the leading address and flow-control bytes are stripped, and only packets addressed to this drop are delivered. A packet ends when its channel sees a zero-token frame after data.

Transmit credit is picked up without any extra traffic. It comes from the spare last payload byte of frames that are not full, and from the flow-control byte of matching channel B packets. All outputs are registered and appear in the cycle after the frame is presented.

Top module: `drop_frame_handler`

## Requirements
- R1: `tick` is high for exactly the one cycle after each cycle with `frm_valid` high, and low otherwise.
- R2: A valid frame with a non-zero tap increments `tick_count` by one, visible the next cycle, wrapping from all ones to zero. Without a valid frame, `tick_count` holds its value.
- R3: A valid frame with tap 0 sets `tick_count` to 0 in the next cycle.
- R4: `slot_grant` pulses for one cycle after a valid frame whose tap equals a non-zero `drop_addr`. It is low after any other frame.
- R5: A channel A frame (`frm_chan`=0) with token n (1 or 2) yields `a_cnt`=n the next cycle. The first payload byte is in `a_data[7:0]` and the second in `a_data[15:8]`.
- R6: `a_eop` pulses after a zero-token channel A frame only if channel A was inside a packet. Channel B frames never open, close or end a channel A packet.
- R7: In a channel B packet whose byte 0 equals the zero-extended `drop_addr`, byte 0 and byte 1 are not delivered. Bytes from index 2 on appear on `b_data`/`b_cnt`, packed from `b_data[7:0]`, whatever their alignment within the frames.
- R8: A channel B packet whose byte 0 differs from the drop address delivers nothing (`b_cnt`=0), raises no `b_eop`, and its byte 1 leaves `credit` unchanged.
- R9: `b_eop` pulses after a zero-token channel B frame that ends a matching channel B packet.
- R10: A valid frame with token 0 or 1, on either channel, loads `credit` with its second payload byte (`frm_b1`) by the next cycle. This takes priority over R11 in the same frame.
- R11: Byte 1 of a matching channel B packet loads `credit`.
- R12: After reset, `tick`, `slot_grant`, `a_eop`, `b_eop`, `a_cnt`, `b_cnt`, `tick_count` and `credit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_addr | input | ADDR_W | Static address of this drop |
| frm_valid | input | 1 | One-cycle strobe marking a decoded frame |
| frm_token | input | 2 | Number of data-carrying payload bytes (values above 2 treated as 2) |
| frm_chan | input | 1 | Channel of the frame: 0 realtime (A), 1 info (B) |
| frm_tap | input | ADDR_W | Tap address of the frame |
| frm_b0 | input | BYTE_W | First payload byte |
| frm_b1 | input | BYTE_W | Second payload byte |
| tick | output | 1 | Time-base pulse |
| tick_count | output | CNT_W | Wrapping frame counter |
| slot_grant | output | 1 | Uplink slot granted to this drop |
| a_data | output | 2*BYTE_W | Channel A payload bytes |
| a_cnt | output | 2 | Number of valid bytes on `a_data` |
| a_eop | output | 1 | End of channel A packet |
| b_data | output | 2*BYTE_W | Delivered channel B data bytes |
| b_cnt | output | 2 | Number of valid bytes on `b_data` |
| b_eop | output | 1 | End of a matching channel B packet |
| credit | output | BYTE_W | Latched transmit credit |

## Verification
The properties check the frame-to-tick relation, the counter step, hold and clear, the slot grant, the channel A byte count, the spare-byte credit capture and the emptiness of end-of-packet cycles on every cycle. Filtering by address, stripping of the header bytes across differing frame alignments, end of packet only for matching channel B packets, and flow-control credit from byte 1 all depend on packet history. Only the bench's directed packet sequences show these. Counter wrap is shown with a narrowed counter.

// File: rtl/drop_frame_handler.sv
module drop_frame_handler #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   drop_addr,
  input  logic                frm_valid,
  input  logic [1:0]          frm_token,
  input  logic                frm_chan,
  input  logic [ADDR_W-1:0]   frm_tap,
  input  logic [BYTE_W-1:0]   frm_b0,
  input  logic [BYTE_W-1:0]   frm_b1,
  output logic                tick,
  output logic [CNT_W-1:0]    tick_count,
  output logic                slot_grant,
  output logic [2*BYTE_W-1:0] a_data,
  output logic [1:0]          a_cnt,
  output logic                a_eop,
  output logic [2*BYTE_W-1:0] b_data,
  output logic [1:0]          b_cnt,
  output logic                b_eop,
  output logic [BYTE_W-1:0]   credit
);
  localparam logic [1:0] HDR_LEN = 2'd2;

  logic       a_open, b_open, b_hit;
  logic [1:0] b_idx;

  wire [1:0]        ntok   = (frm_token > HDR_LEN) ? HDR_LEN : frm_token;
  wire              is_a   = frm_valid & ~frm_chan;
  wire              is_b   = frm_valid & frm_chan;
  wire [BYTE_W-1:0] own    = BYTE_W'(drop_addr);
  wire              b_head = is_b && ntok != 2'd0 && b_idx == 2'd0;
  wire              hit    = b_head ? (frm_b0 == own) : b_hit;
  wire              del0   = ntok >= 2'd1 && b_idx == HDR_LEN && hit;
  wire              del1   = ntok == 2'd2 && b_idx >= 2'd1 && hit;
  wire              fc_0   = b_idx == 2'd1 && ntok >= 2'd1;
  wire              fc_1   = b_idx == 2'd0 && ntok == 2'd2;
  wire              fc_use = is_b && hit && (fc_0 || fc_1);
  wire [BYTE_W-1:0] fc_val = fc_0 ? frm_b0 : frm_b1;
  wire [2:0]        idx_sum = {1'b0, b_idx} + {1'b0, ntok};
  wire [1:0]        idx_nxt = (idx_sum > {1'b0, HDR_LEN}) ? HDR_LEN : idx_sum[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick       <= 1'b0;
      tick_count <= '0;
      slot_grant <= 1'b0;
      a_data     <= '0;
      a_cnt      <= 2'd0;
      a_eop      <= 1'b0;
      a_open     <= 1'b0;
      b_data     <= '0;
      b_cnt      <= 2'd0;
      b_eop      <= 1'b0;
      b_open     <= 1'b0;
      b_hit      <= 1'b0;
      b_idx      <= 2'd0;
      credit     <= '0;
    end else begin
      tick       <= frm_valid;
      slot_grant <= frm_valid && frm_tap == drop_addr && frm_tap != '0;
      if (frm_valid)
        tick_count <= (frm_tap == '0) ? '0 : tick_count + 1'b1;

      a_cnt  <= is_a ? ntok : 2'd0;
      a_data <= {frm_b1, frm_b0};
      a_eop  <= is_a && ntok == 2'd0 && a_open;
      if (is_a) a_open <= ntok != 2'd0;

      b_cnt  <= is_b ? ({1'b0, del0} + {1'b0, del1}) : 2'd0;
      b_data <= del0 ? {frm_b1, frm_b0} : {{BYTE_W{1'b0}}, frm_b1};
      b_eop  <= is_b && ntok == 2'd0 && b_open && b_hit;
      if (is_b) begin
        b_open <= ntok != 2'd0;
        b_hit  <= (ntok != 2'd0) && hit;
        b_idx  <= (ntok == 2'd0) ? 2'd0 : idx_nxt;
      end

      if (frm_valid && frm_token < 2'd2) credit <= frm_b1;
      else if (fc_use)                   credit <= fc_val;
    end
  end
endmodule

// File: rtl/drop_frame_handler_chk.sv
module drop_frame_handler_chk #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] drop_addr,
  input logic              frm_valid,
  input logic [1:0]        frm_token,
  input logic              frm_chan,
  input logic [ADDR_W-1:0] frm_tap,
  input logic [BYTE_W-1:0] frm_b1,
  input logic              tick,
  input logic [CNT_W-1:0]  tick_count,
  input logic              slot_grant,
  input logic [1:0]        a_cnt,
  input logic              a_eop,
  input logic [1:0]        b_cnt,
  input logic              b_eop,
  input logic [BYTE_W-1:0] credit
);
  p_tick_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> tick);
  p_tick_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !tick);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_tap != '0) |=> tick_count == CNT_W'($past(tick_count) + 1'b1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(tick_count));
  p_count_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_tap == '0) |=> tick_count == '0);
  p_grant_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_tap == drop_addr && frm_tap != '0) |=> slot_grant);
  p_grant_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && frm_tap == drop_addr) |=> !slot_grant);
  p_a_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_chan && frm_token != 2'd0 && frm_token <= 2'd2) |=> a_cnt == $past(frm_token));
  p_a_eop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_eop |-> a_cnt == 2'd0);
  p_b_eop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    b_eop |-> (b_cnt == 2'd0 && !a_eop));
  p_spare_credit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_token < 2'd2) |=> credit == $past(frm_b1));
endmodule

bind drop_frame_handler drop_frame_handler_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .drop_addr(drop_addr), .frm_valid(frm_valid),
  .frm_token(frm_token), .frm_chan(frm_chan), .frm_tap(frm_tap), .frm_b1(frm_b1),
  .tick(tick), .tick_count(tick_count), .slot_grant(slot_grant), .a_cnt(a_cnt),
  .a_eop(a_eop), .b_cnt(b_cnt), .b_eop(b_eop), .credit(credit));

// File: tb/drop_frame_handler_tb_top.sv
`timescale 1ns/1ps
module drop_frame_handler_tb_top;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] drop_addr = 5'd5, frm_tap = '0;
  logic frm_valid = 1'b0, frm_chan = 1'b0;
  logic [1:0] frm_token = '0;
  logic [7:0] frm_b0 = '0, frm_b1 = '0, credit;
  logic tick, slot_grant, a_eop, b_eop;
  logic [CW-1:0] tick_count;
  logic [15:0] a_data, b_data;
  logic [1:0] a_cnt, b_cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drop_frame_handler #(.ADDR_W(5), .CNT_W(CW), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .drop_addr(drop_addr), .frm_valid(frm_valid),
    .frm_token(frm_token), .frm_chan(frm_chan), .frm_tap(frm_tap), .frm_b0(frm_b0),
    .frm_b1(frm_b1), .tick(tick), .tick_count(tick_count), .slot_grant(slot_grant),
    .a_data(a_data), .a_cnt(a_cnt), .a_eop(a_eop), .b_data(b_data), .b_cnt(b_cnt),
    .b_eop(b_eop), .credit(credit));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] tok, input logic ch, input logic [4:0] tap,
                       input logic [7:0] b0, input logic [7:0] b1);
    frm_token = tok; frm_chan = ch; frm_tap = tap; frm_b0 = b0; frm_b1 = b1;
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 tick", tick, 0);
    chk("R12 count", tick_count, 0);
    chk("R12 grant", slot_grant, 0);
    chk("R12 credit", credit, 0);
    chk("R12 cnts", {a_cnt, b_cnt, a_eop, b_eop}, 0);
  endtask

  task automatic t_tick();
    frame(2'd0, 1'b0, 5'd3, 8'h00, 8'h00);
    chk("R1 tick after frame", tick, 1);
    chk("R2 count 1", tick_count, 1);
    frame(2'd0, 1'b0, 5'd3, 8'h00, 8'h00);
    chk("R2 count 2", tick_count, 2);
    @(negedge clk);
    chk("R1 no tick idle", tick, 0);
    chk("R2 hold idle", tick_count, 2);
  endtask

  task automatic t_clear_grant();
    frame(2'd0, 1'b0, 5'd0, 8'h00, 8'h00);
    chk("R3 tap zero clears", tick_count, 0);
    chk("R4 no grant on tap 0", slot_grant, 0);
    frame(2'd0, 1'b0, 5'd5, 8'h00, 8'h00);
    chk("R4 grant own tap", slot_grant, 1);
    frame(2'd0, 1'b0, 5'd6, 8'h00, 8'h00);
    chk("R4 no grant other tap", slot_grant, 0);
  endtask

  task automatic t_wrap();
    frame(2'd0, 1'b0, 5'd0, 8'h00, 8'h00);
    for (int i = 0; i < 255; i++) frame(2'd0, 1'b0, 5'd1, 8'h00, 8'h00);
    chk("R2 count at max", tick_count, 255);
    frame(2'd0, 1'b0, 5'd1, 8'h00, 8'h00);
    chk("R2 wrap to zero", tick_count, 0);
  endtask

  task automatic t_chan_a();
    frame(2'd2, 1'b0, 5'd1, 8'h11, 8'h22);
    chk("R5 a_cnt 2", a_cnt, 2);
    chk("R5 a_data", a_data, 16'h2211);
    frame(2'd1, 1'b0, 5'd1, 8'h33, 8'h77);
    chk("R5 a_cnt 1", a_cnt, 1);
    chk("R5 a_data low", a_data[7:0], 8'h33);
    chk("R10 credit from token 1", credit, 8'h77);
    frame(2'd0, 1'b1, 5'd1, 8'h00, 8'h12);
    chk("R6 B frame no a_eop", a_eop, 0);
    chk("R10 credit from token 0", credit, 8'h12);
    frame(2'd0, 1'b0, 5'd1, 8'h00, 8'h13);
    chk("R6 a_eop", a_eop, 1);
    frame(2'd0, 1'b0, 5'd1, 8'h00, 8'h13);
    chk("R6 no a_eop outside packet", a_eop, 0);
  endtask

  task automatic t_b_match();
    frame(2'd2, 1'b1, 5'd1, 8'h05, 8'h30);
    chk("R7 header not delivered", b_cnt, 0);
    chk("R11 fc byte credit", credit, 8'h30);
    frame(2'd2, 1'b1, 5'd1, 8'hAA, 8'hBB);
    chk("R7 b_cnt 2", b_cnt, 2);
    chk("R7 b_data", b_data, 16'hBBAA);
    frame(2'd1, 1'b1, 5'd1, 8'hCC, 8'h44);
    chk("R7 b_cnt 1", b_cnt, 1);
    chk("R7 b_data low", b_data[7:0], 8'hCC);
    chk("R10 spare byte credit", credit, 8'h44);
    frame(2'd0, 1'b1, 5'd1, 8'h00, 8'h09);
    chk("R9 b_eop", b_eop, 1);
    chk("R9 no a_eop", a_eop, 0);
    frame(2'd1, 1'b1, 5'd1, 8'h05, 8'h66);
    chk("R7 addr alone not delivered", b_cnt, 0);
    frame(2'd2, 1'b1, 5'd1, 8'h50, 8'hDD);
    chk("R7 shifted b_cnt", b_cnt, 1);
    chk("R7 shifted b_data", b_data[7:0], 8'hDD);
    chk("R11 fc byte in slot 0", credit, 8'h50);
    frame(2'd0, 1'b1, 5'd1, 8'h00, 8'h21);
    chk("R9 b_eop shifted", b_eop, 1);
  endtask

  task automatic t_b_miss();
    frame(2'd2, 1'b1, 5'd1, 8'h07, 8'h60);
    chk("R8 header other", b_cnt, 0);
    chk("R8 fc ignored", credit, 8'h21);
    frame(2'd2, 1'b1, 5'd1, 8'h01, 8'h02);
    chk("R8 data suppressed", b_cnt, 0);
    chk("R8 credit unchanged", credit, 8'h21);
    frame(2'd0, 1'b1, 5'd1, 8'h00, 8'h21);
    chk("R8 no b_eop", b_eop, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_clear_grant();
    t_wrap();
    t_chan_a();
    t_b_match();
    t_b_miss();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule